// File: doc/BRIEF.md
# Sticky Event Status with Clear-on-Read Interrupt

This block gathers single-cycle terminal-count pulses from seven timer channels and keeps one sticky flag per channel. Software reads the flags through a small register port. That read returns the flags and clears them in the same step. A flag whose pulse arrives in the same cycle as the read is not lost. It stays set and shows up on the next read.

A per-channel enable mask and a two-bit priority field control one shared interrupt request. The request is raised while any enabled flag is set and the priority is nonzero. A single read of the status register removes every request source that the read returned. The interrupt service routine is therefore expected to handle every bit it sees, because several events can be merged into one request.

Register map (address: content): 0 holds the status flags in bits 6:0, cleared on read, and writes to it are ignored. 1 holds the enable mask in bits 6:0. 2 holds the priority in bits 1:0. Any other address reads as zero.

Top module: `evt_status_irq`

## Requirements
- R1: After reset the status flags, the enable mask and the priority are all zero. `rdata`, `irq_o` and `irq_level` are zero, and every register reads back zero.
- R2: A one-cycle high on `evt_i[i]` sets status bit i. The bit stays set through any number of idle cycles until the status register is read.
- R3: `rdata` updates on the clock edge where `rd_en` is sampled high, so it is valid one cycle after the read strobe. A status read returns the flags held before that edge and clears every returned flag.
- R4: An event sampled in the same cycle as a status read is kept set after the read, even though it is absent from the returned data. It appears on the following read.
- R5: `irq_o` is high exactly when the priority is nonzero and at least one status bit is set with its enable bit set. Several flags drive one request.
- R6: A priority of 0 holds `irq_o` low whatever the flags and mask are. Writing a nonzero priority while an enabled flag is pending raises `irq_o`.
- R7: A status read drops `irq_o` in the next cycle unless a new enabled event arrives in the read cycle. A cleared flag cannot re-raise the request.
- R8: The mask at address 1 and the priority at address 2 read back as written. Writes to address 0 leave the status flags unchanged. Reads of an unmapped address return zero.
- R9: `irq_level` always equals the stored priority value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 7 | Per-channel terminal-count pulses |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered |
| irq_o | output | 1 | Shared interrupt request |
| irq_level | output | 2 | Interrupt priority level |

## Verification
The hardest case to reach from the ports is an event pulse that lands in the very cycle the status read is sampled. The bench creates it by raising the read strobe and an event line on the same falling edge and dropping both on the next one. It then checks that the returned data omits the new bit and that a second read shows it. The same collision is repeated with interrupts enabled, to confirm that the request stays up after the clearing read.

// File: rtl/evt_status_irq.sv
module evt_status_irq #(
  parameter int NCH = 7,
  parameter int DW  = 8,
  parameter int AW  = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] evt_i,
  input  logic           rd_en,
  input  logic           wr_en,
  input  logic [AW-1:0]  addr,
  input  logic [DW-1:0]  wdata,
  output logic [DW-1:0]  rdata,
  output logic           irq_o,
  output logic [1:0]     irq_level
);
  localparam logic [AW-1:0] A_STAT = AW'(0);
  localparam logic [AW-1:0] A_MASK = AW'(1);
  localparam logic [AW-1:0] A_PRIO = AW'(2);

  logic [NCH-1:0] status, mask;
  logic [1:0]     prio;
  logic [DW-1:0]  rd_mux;
  logic           unused_wdata;

  wire rd_stat = rd_en && (addr == A_STAT);
  wire [NCH-1:0] clr = status & {NCH{rd_stat}};

  assign unused_wdata = &{1'b0, wdata[DW-1:NCH]};

  always_comb begin
    rd_mux = '0;
    case (addr)
      A_STAT:  rd_mux[NCH-1:0] = status;
      A_MASK:  rd_mux[NCH-1:0] = mask;
      A_PRIO:  rd_mux[1:0]     = prio;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) status <= '0;
    else        status <= (status & ~clr) | evt_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask <= '0;
      prio <= '0;
    end else if (wr_en) begin
      if (addr == A_MASK) mask <= wdata[NCH-1:0];
      if (addr == A_PRIO) prio <= wdata[1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  assign irq_o     = (prio != 2'd0) && |(status & mask);
  assign irq_level = prio;
endmodule

// File: rtl/evt_status_irq_chk.sv
module evt_status_irq_chk #(
  parameter int NCH = 7,
  parameter int DW  = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] evt_i,
  input logic           rd_stat,
  input logic           wr_en,
  input logic [NCH-1:0] status,
  input logic [DW-1:0]  rdata,
  input logic           irq_o,
  input logic [1:0]     irq_level
);
  // R2
  evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i != '0) |=> ((status & $past(evt_i)) == $past(evt_i)));

  // R2
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stat |=> ((status & $past(status)) == $past(status)));

  // R3
  read_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat |=> (rdata[NCH-1:0] == $past(status)));

  // R4
  no_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat |=> (status == $past(evt_i)));

  // R6
  prio_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_level == 2'd0) |-> !irq_o);

  // R7
  read_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && evt_i == '0 && !wr_en) |=> !irq_o);

  // R5
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !rd_stat && !wr_en) |=> irq_o);
endmodule

bind evt_status_irq evt_status_irq_chk #(.NCH(NCH), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .rd_stat(rd_stat),
  .wr_en(wr_en), .status(status), .rdata(rdata), .irq_o(irq_o),
  .irq_level(irq_level)
);

// File: tb/evt_status_irq_bench.sv
module evt_status_irq_bench;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [6:0] evt_i = '0;
  logic       rd_en = 0, wr_en = 0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq_o;
  logic [1:0] irq_level;
  int errors = 0, checks = 0;

  evt_status_irq u_evt_status_irq (.clk(clk), .rst_n(rst_n), .evt_i(evt_i),
    .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq_o(irq_o), .irq_level(irq_level));

  always #5 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic pulse(logic [6:0] e);
    @(negedge clk); evt_i = e;
    @(negedge clk); evt_i = '0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d, input logic [6:0] e = '0);
    @(negedge clk); rd_en = 1; addr = a; evt_i = e;
    @(negedge clk); rd_en = 0; evt_i = '0; d = rdata;
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R1 rdata", rdata, 0); chk("R1 irq", irq_o, 0); chk("R1 level", irq_level, 0);
    for (int a = 0; a < 3; a++) begin rd(2'(a), d); chk("R1 reg", d, 0); end
  endtask

  task automatic t_set_clear;
    logic [7:0] d;
    pulse(7'h04);
    repeat (5) @(negedge clk);
    rd(0, d); chk("R2 sticky", d, 8'h04);
    rd(0, d); chk("R3 cleared", d, 8'h00);
    pulse(7'h01); repeat (2) @(negedge clk); pulse(7'h40);
    rd(0, d); chk("R3 two flags", d, 8'h41);
  endtask

  task automatic t_collide;
    logic [7:0] d;
    pulse(7'h02);
    rd(0, d, 7'h08); chk("R4 returned", d, 8'h02);
    rd(0, d); chk("R4 kept", d, 8'h08);
    rd(0, d); chk("R4 empty", d, 8'h00);
  endtask

  task automatic t_irq;
    logic [7:0] d;
    wr(1, 8'h01); wr(2, 8'h02);
    rd(1, d); chk("R8 mask rb", d, 8'h01);
    rd(2, d); chk("R8 prio rb", d, 8'h02);
    chk("R9 level", irq_level, 2);
    pulse(7'h02); chk("R5 masked ch", irq_o, 0);
    pulse(7'h01); chk("R5 raised", irq_o, 1);
    rd(0, d); chk("R5 data", d, 8'h03); chk("R7 dropped", irq_o, 0);
    repeat (3) @(negedge clk); chk("R7 stays low", irq_o, 0);
  endtask

  task automatic t_prio_zero;
    logic [7:0] d;
    wr(2, 8'h00); chk("R9 level0", irq_level, 0);
    pulse(7'h01); chk("R6 masked", irq_o, 0);
    wr(2, 8'h03); chk("R6 enabled", irq_o, 1); chk("R9 level3", irq_level, 3);
    rd(0, d); chk("R7 clear", irq_o, 0);
  endtask

  task automatic t_merge_and_collide_irq;
    logic [7:0] d;
    wr(1, 8'h7f);
    pulse(7'h10); pulse(7'h20); chk("R5 merged", irq_o, 1);
    rd(0, d); chk("R5 merged data", d, 8'h30); chk("R7 merged drop", irq_o, 0);
    pulse(7'h01);
    rd(0, d, 7'h10); chk("R7 new evt", irq_o, 1); chk("R4 data", d, 8'h01);
    rd(0, d); chk("R4 next", d, 8'h10); chk("R7 final", irq_o, 0);
  endtask

  task automatic t_ignored;
    logic [7:0] d;
    pulse(7'h20);
    wr(0, 8'h00);
    rd(0, d); chk("R8 status write ignored", d, 8'h20);
    rd(3, d); chk("R8 unmapped", d, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset; t_set_clear; t_collide; t_irq; t_prio_zero;
    t_merge_and_collide_irq; t_ignored;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule